// File: doc/BRIEF.md
# Instruction Address Translation Buffer

This block turns the virtual address of an instruction fetch into a physical address. It uses a small set-associative buffer of page translations that software fills. Each way of each set holds two words. The match word carries a tag, a valid flag and a small usage counter. The translate word carries a physical page number, a cache-inhibit flag and two execute-permission flags, one for user mode and one for supervisor mode. A fetch is accepted through a valid/ready handshake. One cycle later the block presents a registered response: a hit with a physical address, a miss exception, or a permission-fault exception. Each exception comes with the faulting virtual address.

When translation is switched off, or the block is built without translation (`MMU_PRESENT = 0`), addresses pass through unchanged. In that case cache-inhibit marks the upper half of the address space. A combinational probe port runs the same lookup for debug or software use. It changes no state and raises nothing. A write port lets software load either word of any entry. A read port returns the match word of any entry, including its usage counter.

Top module: `itlb_xlate`

## Requirements
- R1: Virtual address bits [PAGE_W+SET_W-1:PAGE_W] select the set, and bits [ADDR_W-1:PAGE_W+SET_W] form the tag. A way hits only if its valid flag is set and its stored tag equals that tag.
- R2: When more than one way of the set hits, the way with the highest index supplies the translation.
- R3: On any tag hit of an accepted fetch while translation is on, the hit way's usage counter becomes LRU_STATES-1. Every other way of that set with a nonzero counter drops by one. This applies even when the hit then faults. The counter is read at bits [LRU_W:1] of `rd_match`.
- R4: On a hit, supervisor mode requires translate bit 2 (supervisor execute) and user mode requires translate bit 1 (user execute). If the required bit is clear, the response is a fault with `rsp_paddr` = 0, `rsp_ci` = 0 and `rsp_ea` = the virtual address.
- R5: On a permitted hit, `rsp_paddr` = {physical page number, virtual address bits [PAGE_W-1:0]} and `rsp_ci` = translate bit 0.
- R6: When no way hits, the response is a miss with `rsp_paddr` = 0, `rsp_ci` = 0 and `rsp_ea` = the virtual address.
- R7: With translation off, the response is a hit with `rsp_paddr` = the virtual address and `rsp_ci` = address bit ADDR_W-1 (address ≥ 0x80000000 at the default width). No usage counter changes.
- R8: `probe_paddr` gives the same translation as a fetch would, without a clock. It is 0 on a miss or a permission failure and equals `probe_vaddr` with translation off. It never changes a usage counter.
- R9: A fetch is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its response appears after that edge. `req_ready` = !`rsp_valid` || `rsp_ready`. The response holds stable while `rsp_ready` is low.
- R10: A write with `wr_xlate` = 0 loads the match word: tag from data bits [ADDR_W-1:PAGE_W+SET_W], counter from bits [LRU_W:1] (clamped to LRU_STATES-1), valid from bit 0. With `wr_xlate` = 1 it loads the translate word: page number from bits [ADDR_W-1:PAGE_W], supervisor execute from bit 2, user execute from bit 1, cache-inhibit from bit 0. A fetch accepted in the same cycle as a write still sees the old contents.
- R11: Reset clears every valid flag and usage counter, so every lookup with translation on misses until entries are written.
- R12: Every response raises exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_on | input | 1 | Translation enable |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request can be accepted |
| req_vaddr | input | ADDR_W | Fetch virtual address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | ADDR_W | Physical address, 0 on an exception |
| rsp_ci | output | 1 | Cache-inhibit |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Miss exception |
| rsp_fault | output | 1 | Execute-permission fault exception |
| rsp_ea | output | ADDR_W | Virtual address of the response |
| probe_vaddr | input | ADDR_W | Probe virtual address |
| probe_paddr | output | ADDR_W | Probe result |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | WAY_IW | Way to write |
| wr_set | input | SET_W | Set to write |
| wr_xlate | input | 1 | 0 = match word, 1 = translate word |
| wr_data | input | ADDR_W | Write data |
| rd_way | input | WAY_IW | Way to read |
| rd_set | input | SET_W | Set to read |
| rd_match | output | ADDR_W | Match word of the selected entry |

## Verification
The bench places two valid ways with the same tag in one set. If the first match won instead of the last, the translated address would show the lower way's page. It drives the usage counters down to zero and hits again. Without saturation the counter would wrap to the maximum, and if the hit way's update were missing its counter would not read back at the top value.

Permission checks run in both privilege modes against entries that allow only one mode, so swapping the execute flags turns a hit into a fault. A match word is rewritten in the same cycle a fetch to that set is accepted. Forwarding the new contents would turn the expected hit into a miss. Stalled responses, disabled translation above and below the half-space boundary, and probes of faulting and missing pages cover the remaining paths where state could change wrongly.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    typedef enum logic [1:0] {
        XL_HIT   = 2'd0,
        XL_MISS  = 2'd1,
        XL_FAULT = 2'd2
    } xl_outcome_e;

    // Bit positions inside a stored entry (low end).
    localparam int E_SXE     = 0;
    localparam int E_UXE     = 1;
    localparam int E_CI      = 2;
    localparam int E_PPN_LSB = 3;

    // Bit positions inside a software-written word.
    localparam int W_VALID = 0;
    localparam int W_CI    = 0;
    localparam int W_UXE   = 1;
    localparam int W_SXE   = 2;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/itlb_store.sv
module itlb_store
    import itlb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_W     = 13,
    parameter int SET_W      = 2,
    parameter int WAYS       = 2,
    parameter int LRU_STATES = 4,
    localparam int SETS    = 1 << SET_W,
    localparam int TAG_W   = ADDR_W - PAGE_W - SET_W,
    localparam int PPN_W   = ADDR_W - PAGE_W,
    localparam int ENT_W   = TAG_W + 1 + PPN_W + 3,
    localparam int LRU_W   = idx_w(LRU_STATES),
    localparam int WAY_IW  = idx_w(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAY_IW-1:0] wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_xlate,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [WAY_IW-1:0] upd_way,
    input  logic [SET_W-1:0]  fetch_set,
    input  logic [SET_W-1:0]  probe_set,
    input  logic [WAY_IW-1:0] rd_way,
    input  logic [SET_W-1:0]  rd_set,
    output logic [ENT_W-1:0]  fetch_ent [WAYS],
    output logic [ENT_W-1:0]  probe_ent [WAYS],
    output logic [ADDR_W-1:0] rd_match
);

    localparam int VAL_B   = E_PPN_LSB + PPN_W;
    localparam int TAG_LSB = VAL_B + 1;
    localparam logic [LRU_W-1:0] LRU_MAX = LRU_W'(LRU_STATES - 1);

    logic [ENT_W-1:0] ent_d [SETS][WAYS];
    logic [ENT_W-1:0] ent_q [SETS][WAYS];
    logic [LRU_W-1:0] lru_d [SETS][WAYS];
    logic [LRU_W-1:0] lru_q [SETS][WAYS];

    logic             wr_way_ok;
    logic [LRU_W-1:0] wr_lru;

    assign wr_way_ok = (int'(wr_way) < WAYS);
    assign wr_lru    = (wr_data[LRU_W:1] > LRU_MAX) ? LRU_MAX : wr_data[LRU_W:1];

    always_comb begin
        ent_d = ent_q;
        lru_d = lru_q;
        // usage aging on a hit
        if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (w == int'(upd_way)) begin
                    lru_d[upd_set][w] = LRU_MAX;
                end else if (lru_q[upd_set][w] != '0) begin
                    lru_d[upd_set][w] = lru_q[upd_set][w] - 1'b1;
                end
            end
        end
        // software write wins over aging of the same entry
        if (wr_en && wr_way_ok) begin
            if (!wr_xlate) begin
                ent_d[wr_set][wr_way][TAG_LSB +: TAG_W] = wr_data[ADDR_W-1 -: TAG_W];
                ent_d[wr_set][wr_way][VAL_B]            = wr_data[W_VALID];
                lru_d[wr_set][wr_way]                   = wr_lru;
            end else begin
                ent_d[wr_set][wr_way][E_PPN_LSB +: PPN_W] = wr_data[ADDR_W-1 -: PPN_W];
                ent_d[wr_set][wr_way][E_CI]               = wr_data[W_CI];
                ent_d[wr_set][wr_way][E_UXE]              = wr_data[W_UXE];
                ent_d[wr_set][wr_way][E_SXE]              = wr_data[W_SXE];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '{default: '0};
            lru_q <= '{default: '0};
        end else begin
            ent_q <= ent_d;
            lru_q <= lru_d;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            fetch_ent[w] = ent_q[fetch_set][w];
            probe_ent[w] = ent_q[probe_set][w];
        end
        rd_match = '0;
        if (int'(rd_way) < WAYS) begin
            rd_match[ADDR_W-1 -: TAG_W] = ent_q[rd_set][rd_way][TAG_LSB +: TAG_W];
            rd_match[LRU_W:1]           = lru_q[rd_set][rd_way];
            rd_match[W_VALID]           = ent_q[rd_set][rd_way][VAL_B];
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk_set
        for (genvar w = 0; w < WAYS; w++) begin : g_chk_way
            // R3: counters never pass the top usage state
            a_r3_lru_bound : assert property (@(posedge clk) disable iff (!rst_n)
                lru_q[s][w] <= LRU_MAX);
            // R3: the way that hit holds the top state afterwards
            a_r3_hit_way_top : assert property (@(posedge clk) disable iff (!rst_n)
                (upd_en && int'(upd_set) == s && int'(upd_way) == w &&
                 !(wr_en && !wr_xlate && int'(wr_set) == s && int'(wr_way) == w))
                |=> lru_q[s][w] == LRU_MAX);
        end
    end

endmodule

// File: rtl/itlb_match.sv
module itlb_match
    import itlb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 13,
    parameter int SET_W  = 2,
    parameter int WAYS   = 2,
    localparam int TAG_W  = ADDR_W - PAGE_W - SET_W,
    localparam int PPN_W  = ADDR_W - PAGE_W,
    localparam int ENT_W  = TAG_W + 1 + PPN_W + 3,
    localparam int WAY_IW = idx_w(WAYS)
) (
    input  logic [ENT_W-1:0]  ent [WAYS],
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              sup,
    output logic              hit,
    output logic [WAY_IW-1:0] way,
    output logic              perm_ok,
    output logic [ADDR_W-1:0] xaddr,
    output logic              ci
);

    localparam int VAL_B   = E_PPN_LSB + PPN_W;
    localparam int TAG_LSB = VAL_B + 1;

    logic [TAG_W-1:0] want_tag;
    logic [ENT_W-1:0] sel;

    assign want_tag = vaddr[ADDR_W-1 -: TAG_W];

    always_comb begin
        hit = 1'b0;
        way = '0;
        // ascending scan: the last matching way is kept
        for (int w = 0; w < WAYS; w++) begin
            if (ent[w][VAL_B] && (ent[w][TAG_LSB +: TAG_W] == want_tag)) begin
                hit = 1'b1;
                way = WAY_IW'(w);
            end
        end
        sel     = ent[way];
        perm_ok = sup ? sel[E_SXE] : sel[E_UXE];
        xaddr   = {sel[E_PPN_LSB +: PPN_W], vaddr[PAGE_W-1:0]};
        ci      = sel[E_CI];
    end

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_W      = 13,
    parameter int SET_W       = 2,
    parameter int WAYS        = 2,
    parameter int LRU_STATES  = 4,
    parameter bit MMU_PRESENT = 1'b1,
    localparam int WAY_IW = idx_w(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmu_on,
    input  logic              sup_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_ci,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_ea,
    input  logic [ADDR_W-1:0] probe_vaddr,
    output logic [ADDR_W-1:0] probe_paddr,
    input  logic              wr_en,
    input  logic [WAY_IW-1:0] wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_xlate,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [WAY_IW-1:0] rd_way,
    input  logic [SET_W-1:0]  rd_set,
    output logic [ADDR_W-1:0] rd_match
);

    localparam int TAG_W = ADDR_W - PAGE_W - SET_W;
    localparam int PPN_W = ADDR_W - PAGE_W;
    localparam int ENT_W = TAG_W + 1 + PPN_W + 3;

    typedef struct packed {
        logic              valid;
        xl_outcome_e       outcome;
        logic              ci;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] ea;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              mmu_act;
    logic              accept;
    logic [ENT_W-1:0]  f_ent [WAYS];
    logic [ENT_W-1:0]  p_ent [WAYS];
    logic              f_hit, f_ok, f_ci;
    logic              p_hit, p_ok, p_ci;
    logic [WAY_IW-1:0] f_way, p_way;
    logic [ADDR_W-1:0] f_xaddr, p_xaddr;

    if (MMU_PRESENT) begin : g_mmu
        assign mmu_act = mmu_on;
    end else begin : g_no_mmu
        assign mmu_act = 1'b0;
    end

    assign req_ready = !rsp_q.valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    itlb_store #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SET_W(SET_W),
        .WAYS(WAYS), .LRU_STATES(LRU_STATES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_way    (wr_way),
        .wr_set    (wr_set),
        .wr_xlate  (wr_xlate),
        .wr_data   (wr_data),
        .upd_en    (accept && mmu_act && f_hit),
        .upd_set   (req_vaddr[PAGE_W +: SET_W]),
        .upd_way   (f_way),
        .fetch_set (req_vaddr[PAGE_W +: SET_W]),
        .probe_set (probe_vaddr[PAGE_W +: SET_W]),
        .rd_way    (rd_way),
        .rd_set    (rd_set),
        .fetch_ent (f_ent),
        .probe_ent (p_ent),
        .rd_match  (rd_match)
    );

    itlb_match #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SET_W(SET_W), .WAYS(WAYS)
    ) u_fetch_match (
        .ent     (f_ent),
        .vaddr   (req_vaddr),
        .sup     (sup_mode),
        .hit     (f_hit),
        .way     (f_way),
        .perm_ok (f_ok),
        .xaddr   (f_xaddr),
        .ci      (f_ci)
    );

    itlb_match #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SET_W(SET_W), .WAYS(WAYS)
    ) u_probe_match (
        .ent     (p_ent),
        .vaddr   (probe_vaddr),
        .sup     (sup_mode),
        .hit     (p_hit),
        .way     (p_way),
        .perm_ok (p_ok),
        .xaddr   (p_xaddr),
        .ci      (p_ci)
    );

    always_comb begin
        rsp_d = rsp_q;
        if (rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
        if (accept) begin
            rsp_d.valid = 1'b1;
            rsp_d.ea    = req_vaddr;
            if (!mmu_act) begin
                rsp_d.outcome = XL_HIT;
                rsp_d.paddr   = req_vaddr;
                rsp_d.ci      = req_vaddr[ADDR_W-1];
            end else if (!f_hit) begin
                rsp_d.outcome = XL_MISS;
                rsp_d.paddr   = '0;
                rsp_d.ci      = 1'b0;
            end else if (!f_ok) begin
                rsp_d.outcome = XL_FAULT;
                rsp_d.paddr   = '0;
                rsp_d.ci      = 1'b0;
            end else begin
                rsp_d.outcome = XL_HIT;
                rsp_d.paddr   = f_xaddr;
                rsp_d.ci      = f_ci;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, outcome: XL_MISS, ci: 1'b0, paddr: '0, ea: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_ci    = rsp_q.ci;
    assign rsp_ea    = rsp_q.ea;
    assign rsp_hit   = rsp_q.valid && (rsp_q.outcome == XL_HIT);
    assign rsp_miss  = rsp_q.valid && (rsp_q.outcome == XL_MISS);
    assign rsp_fault = rsp_q.valid && (rsp_q.outcome == XL_FAULT);

    // probe path: no state change, zero on any failure
    always_comb begin
        if (!mmu_act) begin
            probe_paddr = probe_vaddr;
        end else if (p_hit && p_ok) begin
            probe_paddr = p_xaddr;
        end else begin
            probe_paddr = '0;
        end
    end

    // R12: one outcome per response
    a_r12_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R6 / R4: exceptions return a zero address and no cache-inhibit
    a_r6_exc_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> (rsp_paddr == '0 && !rsp_ci));

    // R9: a stalled response holds still
    a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_paddr) && $stable(rsp_ea) && $stable(rsp_hit)));

endmodule

// File: tb/itlb_xlate_tb.sv
module itlb_xlate_tb;

    localparam int AW = 32;
    localparam int PW = 13;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mmu_on = 1'b0, sup_mode = 1'b0;
    logic          req_valid = 1'b0, rsp_ready = 1'b1;
    logic [AW-1:0] req_vaddr = '0, probe_vaddr = '0, wr_data = '0;
    logic          wr_en = 1'b0, wr_xlate = 1'b0;
    logic          wr_way = 1'b0, rd_way = 1'b0;
    logic [SW-1:0] wr_set = '0, rd_set = '0;
    logic          req_ready, rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
    logic [AW-1:0] rsp_paddr, rsp_ea, probe_paddr, rd_match;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    itlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .mmu_on(mmu_on), .sup_mode(sup_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_ci(rsp_ci), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_ea(rsp_ea),
        .probe_vaddr(probe_vaddr), .probe_paddr(probe_paddr),
        .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_xlate(wr_xlate),
        .wr_data(wr_data), .rd_way(rd_way), .rd_set(rd_set), .rd_match(rd_match)
    );

    function automatic logic [31:0] va(input int tag, input int set, input int off);
        return (32'(tag) << 15) | (32'(set) << 13) | 32'(off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_match(input int way, input int set, input int tag, input int lru, input bit v);
        @(negedge clk);
        wr_en = 1'b1; wr_xlate = 1'b0; wr_way = way[0]; wr_set = set[1:0];
        wr_data = (32'(tag) << 15) | (32'(lru) << 1) | 32'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_xl(input int way, input int set, input int ppn, input bit ci, input bit ux, input bit sx);
        @(negedge clk);
        wr_en = 1'b1; wr_xlate = 1'b1; wr_way = way[0]; wr_set = set[1:0];
        wr_data = (32'(ppn) << 13) | {29'd0, sx, ux, ci};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one fetch; returns at the negedge where the response is visible
    task automatic fetch(input logic [31:0] a, input bit on, input bit sup);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = a; mmu_on = on; sup_mode = sup;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // outcome code: 1 hit, 2 miss, 4 fault
    task automatic expect_rsp(input string req, input logic [31:0] pa, input bit ci, input int oc, input logic [31:0] ea);
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " paddr"}, rsp_paddr, pa);
        chk({req, " ci"}, 32'(rsp_ci), 32'(ci));
        chk({req, " outcome R12"}, {29'd0, rsp_fault, rsp_miss, rsp_hit}, 32'(oc));
        chk({req, " ea"}, rsp_ea, ea);
    endtask

    function automatic int lru_of(input int way, input int set);
        rd_way = way[0]; rd_set = set[1:0];
        return 0;
    endfunction

    task automatic chk_lru(input string req, input int way, input int set, input int exp);
        int dummy;
        dummy = lru_of(way, set);
        #1;
        chk(req, 32'(rd_match[2:1]), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R9 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R9 reset req_ready", 32'(req_ready), 1);
        chk_lru("R11 reset counter", 1, 2, 0);
        chk("R11 reset valid", 32'(rd_match[0]), 0);
        fetch(va(0, 0, 0), 1'b1, 1'b1);
        expect_rsp("R11 miss after reset", 32'd0, 1'b0, 2, va(0, 0, 0));
    endtask

    task automatic t_hit();
        wr_match(0, 1, 'h123, 0, 1'b1);
        wr_xl(0, 1, 'h2ABCD, 1'b1, 1'b1, 1'b1);
        fetch(va('h123, 1, 'h0ABC), 1'b1, 1'b1);
        expect_rsp("R5 R1 hit", (32'h2ABCD << 13) | 32'h0ABC, 1'b1, 1, va('h123, 1, 'h0ABC));
        fetch(va('h123, 2, 'h0ABC), 1'b1, 1'b1);
        expect_rsp("R1 R6 other set misses", 32'd0, 1'b0, 2, va('h123, 2, 'h0ABC));
        fetch(va('h124, 1, 'h10), 1'b1, 1'b0);
        expect_rsp("R1 R6 other tag misses", 32'd0, 1'b0, 2, va('h124, 1, 'h10));
        wr_match(1, 1, 'h200, 0, 1'b0);
        fetch(va('h200, 1, 'h10), 1'b1, 1'b1);
        expect_rsp("R1 invalid way misses", 32'd0, 1'b0, 2, va('h200, 1, 'h10));
    endtask

    task automatic t_perm();
        wr_match(1, 2, 'h55, 0, 1'b1);
        wr_xl(1, 2, 'h00777, 1'b0, 1'b0, 1'b1);
        fetch(va('h55, 2, 'h4), 1'b1, 1'b0);
        expect_rsp("R4 user without user-exec", 32'd0, 1'b0, 4, va('h55, 2, 'h4));
        fetch(va('h55, 2, 'h4), 1'b1, 1'b1);
        expect_rsp("R4 supervisor allowed", (32'h777 << 13) | 32'h4, 1'b0, 1, va('h55, 2, 'h4));
        wr_match(0, 3, 'h66, 0, 1'b1);
        wr_xl(0, 3, 'h00100, 1'b0, 1'b1, 1'b0);
        fetch(va('h66, 3, 'h8), 1'b1, 1'b1);
        expect_rsp("R4 supervisor without sup-exec", 32'd0, 1'b0, 4, va('h66, 3, 'h8));
        fetch(va('h66, 3, 'h8), 1'b1, 1'b0);
        expect_rsp("R4 user allowed", (32'h100 << 13) | 32'h8, 1'b0, 1, va('h66, 3, 'h8));
    endtask

    task automatic t_multi();
        wr_match(0, 0, 'h3C, 0, 1'b1);
        wr_xl(0, 0, 'h01111, 1'b0, 1'b1, 1'b1);
        wr_match(1, 0, 'h3C, 0, 1'b1);
        wr_xl(1, 0, 'h02222, 1'b1, 1'b1, 1'b1);
        fetch(va('h3C, 0, 'h20), 1'b1, 1'b1);
        expect_rsp("R2 highest way wins", (32'h2222 << 13) | 32'h20, 1'b1, 1, va('h3C, 0, 'h20));
    endtask

    task automatic t_lru();
        wr_match(0, 1, 'h0A, 0, 1'b1);
        wr_xl(0, 1, 'h00A0A, 1'b0, 1'b1, 1'b1);
        wr_match(1, 1, 'h0B, 2, 1'b1);
        wr_xl(1, 1, 'h00B0B, 1'b0, 1'b1, 1'b1);
        chk_lru("R10 counter written", 1, 1, 2);
        fetch(va('h0A, 1, 0), 1'b1, 1'b1);
        chk_lru("R3 hit way to top", 0, 1, 3);
        chk_lru("R3 other way decrements", 1, 1, 1);
        fetch(va('h0A, 1, 0), 1'b1, 1'b1);
        chk_lru("R3 other reaches zero", 1, 1, 0);
        fetch(va('h0A, 1, 0), 1'b1, 1'b1);
        chk_lru("R3 zero saturates", 1, 1, 0);
        fetch(va('h0B, 1, 0), 1'b1, 1'b1);
        chk_lru("R3 second way to top", 1, 1, 3);
        chk_lru("R3 first way decrements", 0, 1, 2);
        wr_match(0, 1, 'h0A, 7, 1'b1);
        chk_lru("R10 counter clamped", 0, 1, 3);
    endtask

    task automatic t_disabled();
        fetch(32'h8000_1234, 1'b0, 1'b1);
        expect_rsp("R7 pass upper half", 32'h8000_1234, 1'b1, 1, 32'h8000_1234);
        fetch(32'h7FFF_FFFF, 1'b0, 1'b0);
        expect_rsp("R7 pass lower half", 32'h7FFF_FFFF, 1'b0, 1, 32'h7FFF_FFFF);
        fetch(va('h0A, 1, 0), 1'b0, 1'b1);
        expect_rsp("R7 no lookup when off", va('h0A, 1, 0), 1'b0, 1, va('h0A, 1, 0));
        chk_lru("R7 counters untouched", 0, 1, 3);
        chk_lru("R7 counters untouched other", 1, 1, 3);
    endtask

    task automatic t_probe();
        @(negedge clk);
        mmu_on = 1'b1; sup_mode = 1'b1;
        probe_vaddr = va('h55, 2, 'h44);
        #1 chk("R8 probe hit", probe_paddr, (32'h777 << 13) | 32'h44);
        sup_mode = 1'b0;
        #1 chk("R8 probe permission fail", probe_paddr, 32'd0);
        probe_vaddr = va('h99, 2, 'h44);
        #1 chk("R8 probe miss", probe_paddr, 32'd0);
        mmu_on = 1'b0;
        #1 chk("R8 probe disabled", probe_paddr, va('h99, 2, 'h44));
        mmu_on = 1'b1; sup_mode = 1'b1;
        probe_vaddr = va('h0B, 1, 0);
        @(negedge clk);
        @(negedge clk);
        chk_lru("R8 probe leaves counter", 0, 1, 3);
        chk_lru("R8 probe leaves counter hit way", 1, 1, 3);
        chk("R8 probe raises nothing", 32'(rsp_valid), 0);
    endtask

    task automatic t_handshake();
        logic [31:0] p1;
        p1 = (32'h2222 << 13) | 32'h5;
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_vaddr = va('h3C, 0, 'h5);
        mmu_on = 1'b1; sup_mode = 1'b1;
        @(negedge clk);
        req_vaddr = va('h55, 2, 0);
        chk("R9 response after accept", 32'(rsp_valid), 1);
        chk("R9 not ready while stalled", 32'(req_ready), 0);
        chk("R9 stalled data", rsp_paddr, p1);
        @(negedge clk);
        chk("R9 held data", rsp_paddr, p1);
        chk("R9 held ea", rsp_ea, va('h3C, 0, 'h5));
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        chk("R9 drained", 32'(rsp_valid), 0);
    endtask

    task automatic t_same_cycle();
        wr_match(0, 3, 'h77, 0, 1'b1);
        wr_xl(0, 3, 'h00321, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va('h77, 3, 'h1); mmu_on = 1'b1; sup_mode = 1'b1;
        wr_en = 1'b1; wr_xlate = 1'b0; wr_way = 1'b0; wr_set = 2'd3;
        wr_data = 32'h77 << 15;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        expect_rsp("R10 same-cycle write unseen", (32'h321 << 13) | 32'h1, 1'b0, 1, va('h77, 3, 'h1));
        fetch(va('h77, 3, 'h1), 1'b1, 1'b1);
        expect_rsp("R10 write seen next request", 32'd0, 1'b0, 2, va('h77, 3, 'h1));
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_perm();
        t_multi();
        t_lru();
        t_disabled();
        t_probe();
        t_handshake();
        t_same_cycle();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule